// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches three 8-pin GPIO ports, called A, B and F, and turns activity on their pins into interrupt requests. Every pin has its own trigger settings. A mode bit chooses between level and edge detection. A polarity bit chooses between high/rising and low/falling. An enable bit gates whether the pin can request an interrupt, and a filter bit inserts a debounce stage in front of the detector. Edge events are held in a per-pin pending latch. Software releases that latch by writing a one to the pin's acknowledge bit.

Each raw pin passes through a two-flop synchroniser. It then passes through an optional debounce filter, clocked by a slow sampling tick, before detection. Pending bits from ports A and B are merged into one shared request line. Port F drives a separate request line for each pin. Software reaches the settings and the pending state through a byte-wide register bus: writes take effect on the clock edge, and reads return data combinationally.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every mode, polarity, enable and filter bit reads 0, no pin is pending, `irq_ab` is 0 and `irq_f` is 8'h00.
- R2: With mode bit 0 (level), a pin is pending exactly while it is enabled and its qualified input equals its polarity bit (1 = high active, 0 = low active). The pending bit is not latched and drops when the input returns to its inactive level.
- R3: A pin never shows pending while its enable bit is 0. Clearing the enable bit discards a latched edge event, and enabling the pin again does not bring that event back.
- R4: With mode bit 1 (edge), a 0-to-1 change of the qualified input (polarity 1) or a 1-to-0 change (polarity 0) sets the pin's pending bit. The bit stays set after the input returns to its earlier level.
- R5: Writing the acknowledge register clears the pending edge of every pin whose data bit is 1. Pins written with 0 keep their pending state.
- R6: Register map, with one bit per pin and bit i = pin i. The offsets for A/B/F are: mode 0x90/0xAC/0x4C, polarity 0x94/0xB0/0x50, acknowledge 0x98/0xB4/0x54, enable 0x9C/0xB8/0x58, filter 0xA8/0xC4/0x64, pending (read-only) 0xA0/0xBC/0x5C. The settings registers read back what was written. The acknowledge addresses and unmapped addresses read 0.
- R7: `irq_ab` is 1 when any pin of port A or port B is pending. Pending pins of port F do not affect it.
- R8: `irq_f[i]` is 1 exactly while pin i of port F is pending. Ports A and B do not affect it.
- R9: With the filter bit set, the qualified input changes only after DB_COUNT consecutive sampling ticks see the new synchronised value, so a pulse shorter than one tick period is ignored. With the filter bit clear, the same pulse is detected.
- R10: Changing the mode or polarity of a disabled pin whose input is steady creates no pending event when the pin is enabled afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_a | input | 8 | Raw pins of port A |
| pin_b | input | 8 | Raw pins of port B |
| pin_f | input | 8 | Raw pins of port F |
| irq_ab | output | 1 | Shared request of ports A and B |
| irq_f | output | 8 | Per-pin requests of port F |

## Verification
The hardest situations to reach are the ones where nothing should happen. One is a pin whose mode or polarity is flipped while it is disabled. Another is a pulse that is too short to survive the debounce filter. For the first, the bench holds a pin high, toggles the pin's polarity and mode several times with the enable off, then enables it and watches `irq_f` for many cycles. For the second, a three-cycle pulse is sent with the filter on and then again with it off. The same pulse must be ignored in the first case and latched in the second, which shows the silence comes from the filter.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int NPORT  = 3;
    localparam int PIN_W  = 8;
    localparam int ADDR_W = 8;

    // Port index order: A, B, F
    localparam logic [ADDR_W-1:0] OFS_MODE [NPORT] = '{8'h90, 8'hAC, 8'h4C};
    localparam logic [ADDR_W-1:0] OFS_POL  [NPORT] = '{8'h94, 8'hB0, 8'h50};
    localparam logic [ADDR_W-1:0] OFS_ACK  [NPORT] = '{8'h98, 8'hB4, 8'h54};
    localparam logic [ADDR_W-1:0] OFS_ENA  [NPORT] = '{8'h9C, 8'hB8, 8'h58};
    localparam logic [ADDR_W-1:0] OFS_PEND [NPORT] = '{8'hA0, 8'hBC, 8'h5C};
    localparam logic [ADDR_W-1:0] OFS_FILT [NPORT] = '{8'hA8, 8'hC4, 8'h64};

    typedef struct packed {
        logic [PIN_W-1:0] mode;   // 0 level, 1 edge
        logic [PIN_W-1:0] pol;    // 0 low/falling, 1 high/rising
        logic [PIN_W-1:0] ena;
        logic [PIN_W-1:0] filt;
        logic [PIN_W-1:0] latch;  // held edge events
        logic [PIN_W-1:0] prev;   // qualified input one cycle ago
    } port_state_t;

endpackage

// File: rtl/gpio_irq_tick.sv
`timescale 1ns/1ps
module gpio_irq_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pulse;
    } tick_state_t;

    tick_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == CW'(DIV - 1)) begin
            s_d.cnt   = '0;
            s_d.pulse = 1'b1;
        end else begin
            s_d.cnt   = s_q.cnt + CW'(1);
            s_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.pulse;
endmodule

// File: rtl/gpio_irq_filter.sv
`timescale 1ns/1ps
module gpio_irq_filter #(
    parameter int W        = 8,
    parameter int DB_COUNT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] use_filt,
    output logic [W-1:0] qual
);
    localparam int CW = $clog2(DB_COUNT + 1);

    typedef struct packed {
        logic [W-1:0]         s1;
        logic [W-1:0]         s2;
        logic [W-1:0]         stable;
        logic [W-1:0][CW-1:0] cnt;
    } filt_state_t;

    filt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = raw;
        s_d.s2 = s_q.s1;
        if (tick) begin
            for (int i = 0; i < W; i++) begin
                if (s_q.s2[i] != s_q.stable[i]) begin
                    if (s_q.cnt[i] == CW'(DB_COUNT - 1)) begin
                        s_d.stable[i] = s_q.s2[i];
                        s_d.cnt[i]    = '0;
                    end else begin
                        s_d.cnt[i] = s_q.cnt[i] + CW'(1);
                    end
                end else begin
                    s_d.cnt[i] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign qual = (use_filt & s_q.stable) | (~use_filt & s_q.s2);
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int                DB_COUNT = 4,
    parameter logic [ADDR_W-1:0] A_MODE   = 8'h90,
    parameter logic [ADDR_W-1:0] A_POL    = 8'h94,
    parameter logic [ADDR_W-1:0] A_ACK    = 8'h98,
    parameter logic [ADDR_W-1:0] A_ENA    = 8'h9C,
    parameter logic [ADDR_W-1:0] A_PEND   = 8'hA0,
    parameter logic [ADDR_W-1:0] A_FILT   = 8'hA8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [PIN_W-1:0]  pins,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  rd_data,
    output logic [PIN_W-1:0]  pend,
    output logic [PIN_W-1:0]  ena_o,
    output logic [PIN_W-1:0]  mode_o
);
    port_state_t s_d, s_q;

    logic [PIN_W-1:0] qual;
    logic [PIN_W-1:0] rise, fall, hit_edge, ack_bits;

    gpio_irq_filter #(.W(PIN_W), .DB_COUNT(DB_COUNT)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .raw      (pins),
        .use_filt (s_q.filt),
        .qual     (qual)
    );

    always_comb begin
        rise     = qual & ~s_q.prev;
        fall     = ~qual & s_q.prev;
        hit_edge = (s_q.pol & rise) | (~s_q.pol & fall);
        ack_bits = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;

        s_d      = s_q;
        s_d.prev = qual;
        if (bus_wr) begin
            if (bus_addr == A_MODE) s_d.mode = bus_wdata;
            if (bus_addr == A_POL)  s_d.pol  = bus_wdata;
            if (bus_addr == A_ENA)  s_d.ena  = bus_wdata;
            if (bus_addr == A_FILT) s_d.filt = bus_wdata;
        end
        // a fresh edge outranks an acknowledge in the same cycle
        s_d.latch = ((s_q.latch & ~ack_bits) | (s_q.ena & s_q.mode & hit_edge))
                    & s_d.ena & s_d.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = (s_q.mode & s_q.latch)
                | (~s_q.mode & s_q.ena & ~(qual ^ s_q.pol));

    always_comb begin
        rd_data = '0;
        if (bus_addr == A_MODE) rd_data = s_q.mode;
        if (bus_addr == A_POL)  rd_data = s_q.pol;
        if (bus_addr == A_ENA)  rd_data = s_q.ena;
        if (bus_addr == A_FILT) rd_data = s_q.filt;
        if (bus_addr == A_PEND) rd_data = pend;
    end

    assign ena_o  = s_q.ena;
    assign mode_o = s_q.mode;
endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int TICK_DIV = 8,
    parameter int DB_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [PIN_W-1:0]  pin_a,
    input  logic [PIN_W-1:0]  pin_b,
    input  logic [PIN_W-1:0]  pin_f,
    output logic              irq_ab,
    output logic [PIN_W-1:0]  irq_f
);
    logic             tick;
    logic [PIN_W-1:0] pins_v [NPORT];
    logic [PIN_W-1:0] rd_v   [NPORT];
    logic [PIN_W-1:0] pend_v [NPORT];
    logic [PIN_W-1:0] ena_v  [NPORT];
    logic [PIN_W-1:0] mode_v [NPORT];

    logic [PIN_W-1:0] stat_a, stat_b, stat_f;
    logic [PIN_W-1:0] en_a, en_b, en_f, md_f;

    assign pins_v[0] = pin_a;
    assign pins_v[1] = pin_b;
    assign pins_v[2] = pin_f;

    gpio_irq_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        gpio_irq_port #(
            .DB_COUNT (DB_COUNT),
            .A_MODE   (OFS_MODE[p]),
            .A_POL    (OFS_POL[p]),
            .A_ACK    (OFS_ACK[p]),
            .A_ENA    (OFS_ENA[p]),
            .A_PEND   (OFS_PEND[p]),
            .A_FILT   (OFS_FILT[p])
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .pins      (pins_v[p]),
            .bus_wr    (bus_wr),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .rd_data   (rd_v[p]),
            .pend      (pend_v[p]),
            .ena_o     (ena_v[p]),
            .mode_o    (mode_v[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NPORT; p++) bus_rdata = bus_rdata | rd_v[p];
    end

    assign stat_a = pend_v[0];
    assign stat_b = pend_v[1];
    assign stat_f = pend_v[2];
    assign en_a   = ena_v[0];
    assign en_b   = ena_v[1];
    assign en_f   = ena_v[2];
    assign md_f   = mode_v[2];

    assign irq_ab = |(stat_a | stat_b);
    assign irq_f  = stat_f;
endmodule

// File: rtl/gpio_irq_chk.sv
`timescale 1ns/1ps
module gpio_irq_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PIN_W-1:0]  bus_wdata,
    input logic              irq_ab,
    input logic [PIN_W-1:0]  stat_a,
    input logic [PIN_W-1:0]  stat_b,
    input logic [PIN_W-1:0]  stat_f,
    input logic [PIN_W-1:0]  en_a,
    input logic [PIN_W-1:0]  en_b,
    input logic [PIN_W-1:0]  en_f,
    input logic [PIN_W-1:0]  md_f
);
    logic [PIN_W-1:0] ack_f;
    assign ack_f = (bus_wr && bus_addr == OFS_ACK[2]) ? bus_wdata : '0;

    a_r3_gate_a: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_a & ~en_a) == '0);
    a_r3_gate_b: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_b & ~en_b) == '0);
    a_r3_gate_f: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_f & ~en_f) == '0);

    // R10: a newly pending edge pin was already enabled the cycle before
    a_r10_no_cold_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_f & ~$past(stat_f) & md_f & ~$past(en_f)) == '0);

    // R4 and R5: an edge pin stays pending unless acknowledged, disabled or switched
    a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_f & md_f & ~ack_f) & en_f & md_f & ~stat_f) == '0);

    a_r7_ab_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a | en_b) == '0 |-> !irq_ab);
endmodule

bind gpio_irq_ctrl gpio_irq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_ab    (irq_ab),
    .stat_a    (stat_a),
    .stat_b    (stat_b),
    .stat_f    (stat_f),
    .en_a      (en_a),
    .en_b      (en_b),
    .en_f      (en_f),
    .md_f      (md_f)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
    logic       irq_ab;
    logic [7:0] irq_f;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.TICK_DIV(8), .DB_COUNT(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_a(pin_a),
        .pin_b(pin_b), .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic do_reset();
        pin_a = '0; pin_b = '0; pin_f = '0;
        @(negedge clk); rst_n = 1'b0;
        cyc(2); rst_n = 1'b1; cyc(2);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(8'h90, v); check("R1 mode A", v, 8'h00);
        rd(8'hB8, v); check("R1 enable B", v, 8'h00);
        rd(8'h64, v); check("R1 filter F", v, 8'h00);
        rd(8'h5C, v); check("R1 pending F", v, 8'h00);
        check("R1 irq_ab", {7'b0, irq_ab}, 8'h00);
        check("R1 irq_f", irq_f, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        wr(8'h90, 8'h5A); rd(8'h90, v); check("R6 mode A readback", v, 8'h5A);
        wr(8'hB0, 8'hC3); rd(8'hB0, v); check("R6 pol B readback", v, 8'hC3);
        wr(8'h64, 8'h81); rd(8'h64, v); check("R6 filter F readback", v, 8'h81);
        rd(8'h98, v); check("R6 ack reads 0", v, 8'h00);
        rd(8'h00, v); check("R6 unmapped reads 0", v, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] v;
        do_reset();
        wr(8'h94, 8'h04); wr(8'h9C, 8'h04);
        pin_a[2] = 1'b1; cyc(4);
        rd(8'hA0, v); check("R2 level high pending", v, 8'h04);
        check("R7 irq_ab from A", {7'b0, irq_ab}, 8'h01);
        pin_a[2] = 1'b0; cyc(4);
        rd(8'hA0, v); check("R2 level not latched", v, 8'h00);
        wr(8'h94, 8'h00); cyc(2);
        rd(8'hA0, v); check("R2 level low pending", v, 8'h04);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        do_reset();
        wr(8'h4C, 8'h20); wr(8'h50, 8'h20); wr(8'h58, 8'h20);
        pin_f[5] = 1'b1; cyc(5);
        check("R4 rising latched", irq_f, 8'h20);
        check("R7 F not on irq_ab", {7'b0, irq_ab}, 8'h00);
        pin_f[5] = 1'b0; cyc(5);
        check("R4 held after return", irq_f, 8'h20);
        wr(8'h54, 8'hDF); cyc(1);
        check("R5 zero bit no effect", irq_f, 8'h20);
        wr(8'h54, 8'h20); cyc(1);
        check("R5 ack clears", irq_f, 8'h00);
        wr(8'h50, 8'h00);
        pin_f[5] = 1'b1; cyc(5);
        check("R4 falling ignores rise", irq_f, 8'h00);
        pin_f[5] = 1'b0; cyc(5);
        check("R4 falling latched", irq_f, 8'h20);
        rd(8'h5C, v); check("R8 pending F reg", v, 8'h20);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        do_reset();
        wr(8'hAC, 8'h01); wr(8'hB0, 8'h01);
        pin_b[0] = 1'b1; cyc(5);
        rd(8'hBC, v); check("R3 disabled no pend", v, 8'h00);
        pin_b[0] = 1'b0; cyc(4);
        wr(8'hB8, 8'h01);
        pin_b[0] = 1'b1; cyc(5);
        rd(8'hBC, v); check("R3 enabled edge", v, 8'h01);
        wr(8'hB8, 8'h00); cyc(1);
        rd(8'hBC, v); check("R3 disable drops", v, 8'h00);
        wr(8'hB8, 8'h01); cyc(3);
        rd(8'hBC, v); check("R3 not restored", v, 8'h00);
    endtask

    task automatic t_shared();
        do_reset();
        wr(8'h94, 8'h80); wr(8'h9C, 8'h80);
        wr(8'hB0, 8'h08); wr(8'hB8, 8'h08);
        pin_b[3] = 1'b1; cyc(4);
        check("R7 irq_ab from B", {7'b0, irq_ab}, 8'h01);
        check("R8 F untouched by B", irq_f, 8'h00);
        pin_b[3] = 1'b0; pin_a[7] = 1'b1; cyc(4);
        check("R7 irq_ab from A pin7", {7'b0, irq_ab}, 8'h01);
        pin_a[7] = 1'b0; cyc(4);
        check("R7 irq_ab idle", {7'b0, irq_ab}, 8'h00);
    endtask

    task automatic t_f_lines();
        do_reset();
        wr(8'h50, 8'h81); wr(8'h58, 8'h81);
        pin_f[0] = 1'b1; cyc(4);
        check("R8 line 0", irq_f, 8'h01);
        pin_f[7] = 1'b1; cyc(4);
        check("R8 lines 0 and 7", irq_f, 8'h81);
    endtask

    task automatic t_debounce();
        logic [7:0] v;
        do_reset();
        wr(8'h90, 8'h10); wr(8'h94, 8'h10); wr(8'hA8, 8'h10); wr(8'h9C, 8'h10);
        cyc(4);
        pin_a[4] = 1'b1; cyc(3); pin_a[4] = 1'b0; cyc(60);
        rd(8'hA0, v); check("R9 glitch filtered", v, 8'h00);
        pin_a[4] = 1'b1; cyc(60);
        rd(8'hA0, v); check("R9 long pulse passes", v, 8'h10);
        pin_a[4] = 1'b0; cyc(60);
        wr(8'h98, 8'h10); wr(8'hA8, 8'h00); cyc(2);
        rd(8'hA0, v); check("R9 cleared before unfiltered", v, 8'h00);
        pin_a[4] = 1'b1; cyc(3); pin_a[4] = 1'b0; cyc(6);
        rd(8'hA0, v); check("R9 glitch seen unfiltered", v, 8'h10);
    endtask

    task automatic t_no_spurious();
        do_reset();
        pin_f[1] = 1'b1; cyc(5);
        wr(8'h4C, 8'h02); wr(8'h50, 8'h02); wr(8'h50, 8'h00);
        wr(8'h4C, 8'h00); wr(8'h4C, 8'h02); wr(8'h50, 8'h02);
        cyc(2);
        wr(8'h58, 8'h02); cyc(10);
        check("R10 no event after reconfig", irq_f, 8'h00);
        wr(8'h50, 8'h00); cyc(10);
        check("R10 no event on polarity flip", irq_f, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_enable();
        t_shared();
        t_f_lines();
        t_debounce();
        t_no_spurious();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule